// File: doc/BRIEF.md
# Three-Dimensional Element Index Remapper

This block replaces the plain 0, 1, 2, ... element counter of a vector loop with a remapped sequence. Inside it, three per-axis counters form a nested counter. A programmable permutation sets which axis counts fastest and the order in which carries ripple. Each step folds the counter into a linear element index using mixed-radix weights. The block supports a starting offset, reversal of any axis and masking of the low axes, so one loop can walk a register as a transposed matrix, a rotated sequence or a broadcast pattern.

A `start` pulse latches the configuration and clears the counters. The block then pre-advances the counter by the offset, one step per cycle, with `busy` high. After that, each accepted `step` yields one registered index with `idx_valid`. `done` marks the index that completes the programmed loop length. An operation that remaps several operands at once uses one instance per operand.

Top module: `elem_remap_gen`

## Requirements
- R1: Each axis limit is 1 to 16, and a limit of 0 is taken as 1. The emitted index is a0 + a1*X + a2*X*Y, where X and Y are the clamped x and y limits and a0..a2 are the per-axis terms. Axis 0 is x, axis 1 is y and axis 2 is z.
- R2: `order[1:0]` names the axis that increments on every step. When that axis reaches its limit it returns to 0 and carries into the axis named by `order[3:2]`, which in turn carries into the axis named by `order[5:4]`. The axis codes are 0 for x, 1 for y and 2 for z, and the three fields form a permutation.
- R3: After `start`, `busy` is high for exactly `offset` cycles while the counter pre-advances by `offset` steps under the R2 carry rules. A `step` during that time is ignored, and `busy` never coincides with `idx_valid`.
- R4: When `rev[i]` is set, axis i contributes (limit_i - 1 - count_i) instead of count_i.
- R5: Every axis i with i < `apply_dim` contributes 0 to the index.
- R6: A `step` sampled at clock edge k, while the block is running, produces its index with `idx_valid` high for one cycle after edge k+1. A `step` that is not sampled produces no output.
- R7: `done` is high together with the index of the `loop_len`-th step and at no other time. Steps after that are ignored. A `loop_len` longer than X*Y*Z wraps the counter, and the sequence repeats.
- R8: Reset and `start` both clear `busy`, `idx_valid` and `done`. A `start` during a run abandons that run, including any index still in flight.
- R9: With `loop_len` equal to 0, the block emits no index after the pre-advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Latch configuration, clear counters, begin pre-advance |
| step | input | 1 | Request the next index |
| lim_x | input | 5 | Limit of axis 0 (0 treated as 1) |
| lim_y | input | 5 | Limit of axis 1 |
| lim_z | input | 5 | Limit of axis 2 |
| order | input | 6 | Carry order: three 2-bit axis codes, fastest in [1:0] |
| offset | input | 12 | Number of pre-advance steps |
| rev | input | 3 | Per-axis reversal flags |
| apply_dim | input | 2 | Axes numbered below this contribute zero |
| loop_len | input | 16 | Number of indices to emit |
| busy | output | 1 | Pre-advance in progress |
| idx_valid | output | 1 | `idx` holds a new index |
| done | output | 1 | This index is the last of the loop |
| idx | output | 12 | Remapped linear element index |

## Verification
The assertions assume that `order` holds a true permutation of the three axis codes and that `start` comes while `step` is ignored or irrelevant. The stimulus draws every order from the six legal permutations and never produces a duplicate axis code. `step` is held high across `start` and the pre-advance on purpose, so any output accepted during `busy` would show up. The sweeps use small limits, where every permutation, reversal mask and apply threshold can be compared against an arithmetic model of the nested counter. Separate runs cover the largest limits, zero limits, wrapping loop lengths and a restart in mid-run.

// File: rtl/elem_remap_gen.sv
module elem_remap_gen #(
  parameter int CW    = 4,
  parameter int OFS_W = 12,
  parameter int LEN_W = 16,
  localparam int LW    = CW + 1,
  localparam int IDX_W = 3 * CW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  input  logic [LW-1:0]    lim_x,
  input  logic [LW-1:0]    lim_y,
  input  logic [LW-1:0]    lim_z,
  input  logic [5:0]       order,
  input  logic [OFS_W-1:0] offset,
  input  logic [2:0]       rev,
  input  logic [1:0]       apply_dim,
  input  logic [LEN_W-1:0] loop_len,
  output logic             busy,
  output logic             idx_valid,
  output logic             done,
  output logic [IDX_W-1:0] idx
);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_RUN} state_t;

  state_t           st;
  logic [LW-1:0]    lim_q  [4];
  logic [CW-1:0]    cnt    [4];
  logic [CW-1:0]    cnt_nx [4];
  logic [CW-1:0]    term   [3];
  logic [CW-1:0]    term_q [3];
  logic [5:0]       ord_q;
  logic [2:0]       rev_q;
  logic [1:0]       ap_q;
  logic [LW-1:0]    w1;
  logic [2*LW-1:0]  w2;
  logic [OFS_W-1:0] ofs_left;
  logic [LEN_W-1:0] rem;
  logic             v1, last1;

  function automatic logic [LW-1:0] clamp1(input logic [LW-1:0] l);
    return (l == '0) ? LW'(1) : l;
  endfunction

  assign busy = (st == S_PRE);

  always_comb begin : advance
    logic          carry;
    logic [1:0]    d;
    logic [LW-1:0] bump;
    cnt_nx = cnt;
    carry  = 1'b1;
    for (int i = 0; i < 3; i++) begin
      d    = ord_q[2*i +: 2];
      bump = {1'b0, cnt[d]} + LW'(1);
      if (carry && d != 2'd3) begin
        if (bump == lim_q[d]) cnt_nx[d] = '0;
        else begin
          cnt_nx[d] = bump[CW-1:0];
          carry     = 1'b0;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      if (2'(i) < ap_q)  term[i] = '0;
      else if (rev_q[i]) term[i] = lim_q[i][CW-1:0] - CW'(1) - cnt[i];
      else               term[i] = cnt[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ord_q     <= '0;
      rev_q     <= '0;
      ap_q      <= '0;
      w1        <= LW'(1);
      w2        <= (2*LW)'(1);
      ofs_left  <= '0;
      rem       <= '0;
      v1        <= 1'b0;
      last1     <= 1'b0;
      idx_valid <= 1'b0;
      done      <= 1'b0;
      idx       <= '0;
      for (int i = 0; i < 4; i++) begin
        lim_q[i] <= LW'(1);
        cnt[i]   <= '0;
      end
      for (int i = 0; i < 3; i++) term_q[i] <= '0;
    end else begin
      v1        <= 1'b0;
      last1     <= 1'b0;
      idx_valid <= v1;
      done      <= v1 & last1;
      if (v1)
        idx <= IDX_W'(term_q[0])
             + IDX_W'(term_q[1]) * IDX_W'(w1)
             + IDX_W'(term_q[2]) * IDX_W'(w2);
      if (start) begin
        lim_q[0]  <= clamp1(lim_x);
        lim_q[1]  <= clamp1(lim_y);
        lim_q[2]  <= clamp1(lim_z);
        lim_q[3]  <= LW'(1);
        w1        <= clamp1(lim_x);
        w2        <= (2*LW)'(clamp1(lim_x)) * (2*LW)'(clamp1(lim_y));
        ord_q     <= order;
        rev_q     <= rev;
        ap_q      <= apply_dim;
        ofs_left  <= offset;
        rem       <= loop_len;
        idx_valid <= 1'b0;
        done      <= 1'b0;
        for (int i = 0; i < 4; i++) cnt[i] <= '0;
        if (offset != '0)        st <= S_PRE;
        else if (loop_len != '0) st <= S_RUN;
        else                     st <= S_IDLE;
      end else begin
        case (st)
          S_PRE: begin
            cnt      <= cnt_nx;
            ofs_left <= ofs_left - OFS_W'(1);
            if (ofs_left == OFS_W'(1)) st <= (rem != '0) ? S_RUN : S_IDLE;
          end
          S_RUN: if (step) begin
            term_q <= term;
            v1     <= 1'b1;
            last1  <= (rem == LEN_W'(1));
            cnt    <= cnt_nx;
            rem    <= rem - LEN_W'(1);
            if (rem == LEN_W'(1)) st <= S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/elem_remap_gen_chk.sv
module elem_remap_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic step,
  input logic busy,
  input logic idx_valid,
  input logic done
);

  p_done_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> idx_valid);

  p_valid_after_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid |-> $past(step, 2));

  p_busy_no_output_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !idx_valid);

  p_busy_from_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_start_flushes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!idx_valid && !done));

endmodule

bind elem_remap_gen elem_remap_gen_chk u_chk (.*);

// File: tb/tb_elem_remap_gen.sv
module tb_elem_remap_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        step = 1'b0;
  logic [4:0]  lim_x = '0, lim_y = '0, lim_z = '0;
  logic [5:0]  order = 6'b100100;
  logic [11:0] offset = '0;
  logic [2:0]  rev = '0;
  logic [1:0]  apply_dim = '0;
  logic [15:0] loop_len = '0;
  logic        busy, idx_valid, done;
  logic [11:0] idx;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  int exp_q[$];

  localparam logic [5:0] PERMS [6] = '{6'b100100, 6'b011000, 6'b100001,
                                        6'b001001, 6'b010010, 6'b000110};

  always #10 clk = ~clk;

  elem_remap_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step),
    .lim_x(lim_x), .lim_y(lim_y), .lim_z(lim_z), .order(order),
    .offset(offset), .rev(rev), .apply_dim(apply_dim), .loop_len(loop_len),
    .busy(busy), .idx_valid(idx_valid), .done(done), .idx(idx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic void model(input int x, input int y, input int z,
                                input logic [5:0] ord, input int ofs,
                                input logic [2:0] rv, input int ap, input int len);
    int lim [3];
    int c [3];
    int t [3];
    lim[0] = (x == 0) ? 1 : x;
    lim[1] = (y == 0) ? 1 : y;
    lim[2] = (z == 0) ? 1 : z;
    c = '{0, 0, 0};
    exp_q.delete();
    for (int n = 0; n < ofs + len; n++) begin
      if (n >= ofs) begin
        for (int i = 0; i < 3; i++) begin
          t[i] = (i < ap) ? 0 : (rv[i] ? lim[i] - 1 - c[i] : c[i]);
        end
        exp_q.push_back(t[0] + t[1] * lim[0] + t[2] * lim[0] * lim[1]);
      end
      for (int i = 0; i < 3; i++) begin
        int d;
        d = int'(ord[2*i +: 2]);
        c[d]++;
        if (c[d] != lim[d]) break;
        c[d] = 0;
      end
    end
  endfunction

  task automatic run(input int x, input int y, input int z, input logic [5:0] ord,
                     input int ofs, input logic [2:0] rv, input int ap,
                     input int len, input string tag);
    int n, bcnt;
    model(x, y, z, ord, ofs, rv, ap, len);
    @(negedge clk);
    lim_x = 5'(x); lim_y = 5'(y); lim_z = 5'(z);
    order = ord; offset = 12'(ofs); rev = rv; apply_dim = 2'(ap);
    loop_len = 16'(len);
    start = 1'b1;
    step  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!idx_valid && !done, "R8", int'({idx_valid, done}), 0);
    n = 0;
    bcnt = 0;
    for (int c = 0; c < ofs + len + 6; c++) begin
      if (busy) bcnt++;
      if (idx_valid) begin
        if (n >= len) chk(0, "R7", n + 1, len);
        else begin
          chk(idx == 12'(exp_q[n]), tag, int'(idx), exp_q[n]);
          chk(done == (n == len - 1), "R7", int'(done), int'(n == len - 1));
        end
        n++;
      end else if (done) chk(0, "R7", 1, 0);
      @(negedge clk);
    end
    step = 1'b0;
    chk(bcnt == ofs, "R3", bcnt, ofs);
    chk(n == len, (len == 0) ? "R9" : "R7", n, len);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !idx_valid && !done, "R8", int'({busy, idx_valid, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: single step latency
    lim_x = 5'd2; lim_y = 5'd2; lim_z = 5'd1; order = PERMS[0];
    offset = '0; rev = '0; apply_dim = '0; loop_len = 16'd4;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    step  = 1'b1;
    @(negedge clk);
    step = 1'b0;
    chk(!idx_valid, "R6", int'(idx_valid), 0);
    @(negedge clk);
    chk(idx_valid && idx == 12'd0, "R6", int'(idx), 0);
    @(negedge clk);
    chk(!idx_valid, "R6", int'(idx_valid), 0);

    // R1 R3: rotated walk of a 3x4 plane
    run(3, 4, 1, PERMS[0], 2, 3'b000, 0, 12, "R1");

    // R2: every carry order over small shapes, with mixed offsets, reversal, masking
    for (int x = 1; x <= 3; x++)
      for (int y = 1; y <= 3; y++)
        for (int z = 1; z <= 2; z++)
          for (int p = 0; p < 6; p++)
            run(x, y, z, PERMS[p], (x + p) % 4, 3'((x * y + p) & 7),
                (p + z) % 4, x * y * z, "R2");

    // R4 R5: all reversal masks against all apply thresholds
    for (int r = 0; r < 8; r++)
      for (int a = 0; a < 4; a++)
        run(2, 3, 2, PERMS[3], 1, 3'(r), a, 12, (a == 0) ? "R4" : "R5");

    // R7: wrap-around over three full passes
    run(4, 2, 3, PERMS[4], 5, 3'b010, 0, 72, "R7");

    // R1: zero limits become one
    run(0, 5, 0, PERMS[5], 1, 3'b000, 0, 5, "R1");

    // R1: largest shape
    run(16, 16, 16, PERMS[1], 100, 3'b101, 0, 4096, "R1");

    // R9: empty loop after pre-advance
    run(3, 3, 3, PERMS[0], 3, 3'b000, 0, 0, "R9");

    // R8: restart in mid-run
    @(negedge clk);
    lim_x = 5'd4; lim_y = 5'd4; lim_z = 5'd1; order = PERMS[2];
    offset = '0; rev = '0; apply_dim = '0; loop_len = 16'd16;
    start = 1'b1;
    step  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    run(3, 2, 2, PERMS[5], 2, 3'b110, 1, 12, "R8");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule